// File: doc/BRIEF.md
# Pipelined Burst SRAM Command Controller

This block models the synchronous control path of a single-port burst SRAM that is built for back-to-back reads and writes with no bus turnaround. On each enabled rising clock edge it samples the select inputs, the load/advance strobe, the write strobe and the per-byte write strobes, and turns them into one cycle type: begin read, begin write (or write abort), continue the current burst, deselect, or continue a deselect. It keeps a 2-bit linear burst counter and moves each operation through a two-stage pipeline into a small behavioural memory. The read data register drives the data bus through a tri-state enable.

Both reads and writes finish two enabled edges after their address is sampled. Reads and writes can therefore alternate on every cycle with no idle cycle between them. A clock-enable input freezes the whole pipeline for one edge. An output-enable input and a sleep input gate the bus drive without waiting for a clock edge.

Top module: `pbsram_ctrl`

## Requirements
- R1: While reset is asserted and after reset is released, with no command issued, `dq_oe` is low.
- R2: A begin-read is sampled with `adv`=0, `cs_n`=0, `cs`=1 and `we_n`=1 on an enabled edge E0. After enabled edge E2, `rdata` holds the memory word at that address and `dq_oe` is high, provided `oe_n` is low.
- R3: A begin-write is sampled on an enabled edge E0 with `we_n`=0. On enabled edge E2, each byte b of the target word for which `bw_n[b]` was 0 at E0 takes `wdata[8b+7:8b]` as it stands at E2. Every other byte keeps its value.
- R4: Each continue cycle (`adv`=1) of a read or write burst steps the two low address bits by one, modulo 4, starting from the loaded address. The upper address bits stay as loaded.
- R5: A continue cycle repeats the operation type of the burst last begun: a read after a begin-read, and a write after a begin-write. A write continue uses the `bw_n` sampled on the continue cycle.
- R6: A write with every `bw_n` bit at 1 (write abort) leaves the memory unchanged. The burst counter still loads or steps as for a write.
- R7: A load cycle with the chip deselected (`cs_n`=1 or `cs`=0) transfers no data. A continue cycle that follows a deselect is also a no-op, and so is one after reset.
- R8: On an edge with `cken_n`=1, no input is sampled and no register changes. A driven bus stays driven with the same data, and an undriven bus stays undriven.
- R9: `dq_oe` is high only when the output register holds read data, `oe_n` is low and `sleep` is low. Write cycles never drive the bus. A read with `oe_n` high is a dummy read.
- R10: `sleep` high forces `dq_oe` low at once, with no clock edge needed. Edges sampled while `sleep` is high act as deselects. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cken_n | input | 1 | Clock enable, active low; high inserts a wait state |
| cs_n | input | 1 | Active-low chip select |
| cs | input | 1 | Active-high chip select |
| adv | input | 1 | 0 = load external address, 1 = continue burst |
| we_n | input | 1 | Write strobe, active low |
| bw_n | input | BYTES | Per-byte write strobes, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Sleep request, asynchronous |
| wdata | input | 8*BYTES | Write data bus |
| rdata | output | 8*BYTES | Read data register |
| dq_oe | output | 1 | Tri-state enable for the data bus |

## Verification
The hardest situations to reach are the ones where the pipeline holds a read and a write at the same time, at the moment a stall, a sleep request or an output-enable change arrives. In that state the bus drive must reflect only the stage-two operation. The bench reaches it by placing stalls and sleep pulses inside alternating read/write bursts that start at unaligned addresses. It then runs a long random mix of all controls against a behavioural model, so that a deselect-continue, an abort continue and a stall also fall within wrapping bursts.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  typedef enum logic [1:0] {
    BK_IDLE = 2'd0,
    BK_RD   = 2'd1,
    BK_WR   = 2'd2
  } bkind_e;
endpackage

// File: rtl/pbs_cmd_decode.sv
module pbs_cmd_decode
  import pbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic          sleep,
  input  logic          cs_n,
  input  logic          cs,
  input  logic          adv,
  input  logic          we_n,
  input  logic [NB-1:0] bw_n,
  input  logic [AW-1:0] addr,
  input  bkind_e        bkind_q,
  input  logic [AW-3:0] base_hi_q,
  input  logic [1:0]    cnt_q,
  output op_e           op,
  output logic [AW-1:0] eff_addr,
  output logic [NB-1:0] mask,
  output logic          upd,
  output bkind_e        bkind_d
);
  always_comb begin
    op       = OP_NONE;
    mask     = '0;
    upd      = 1'b0;
    bkind_d  = bkind_q;
    eff_addr = {base_hi_q, 2'(cnt_q + 2'd1)};
    if (sleep) begin
      bkind_d = BK_IDLE;
    end else if (!adv) begin
      if (!cs_n && cs) begin
        upd      = 1'b1;
        eff_addr = addr;
        if (!we_n) begin
          op      = OP_WR;
          mask    = ~bw_n;
          bkind_d = BK_WR;
        end else begin
          op      = OP_RD;
          bkind_d = BK_RD;
        end
      end else begin
        bkind_d = BK_IDLE;
      end
    end else begin
      case (bkind_q)
        BK_RD: begin
          op  = OP_RD;
          upd = 1'b1;
        end
        BK_WR: begin
          op   = OP_WR;
          mask = ~bw_n;
          upd  = 1'b1;
        end
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/pbs_burst_addr.sv
module pbs_burst_addr
  import pbs_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke,
  input  logic          upd,
  input  logic [AW-1:0] eff_addr,
  input  bkind_e        bkind_d,
  output bkind_e        bkind_q,
  output logic [AW-3:0] base_hi_q,
  output logic [1:0]    cnt_q
);
  logic [AW-3:0] base_hi_d;
  logic [1:0]    cnt_d;

  always_comb begin
    base_hi_d = base_hi_q;
    cnt_d     = cnt_q;
    if (upd) begin
      base_hi_d = eff_addr[AW-1:2];
      cnt_d     = eff_addr[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bkind_q   <= BK_IDLE;
      base_hi_q <= '0;
      cnt_q     <= '0;
    end else if (cke) begin
      bkind_q   <= bkind_d;
      base_hi_q <= base_hi_d;
      cnt_q     <= cnt_d;
    end
  end
endmodule

// File: rtl/pbs_data_pipe.sv
module pbs_data_pipe
  import pbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cke,
  input  op_e             op_in,
  input  logic [AW-1:0]   addr_in,
  input  logic [NB-1:0]   mask_in,
  input  logic [8*NB-1:0] wdata,
  output op_e             s1_op,
  output logic [AW-1:0]   s1_addr,
  output logic [NB-1:0]   s1_mask,
  output op_e             s2_op,
  output logic            drv_q,
  output logic [8*NB-1:0] dout_q
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = 8 * NB;

  logic [AW-1:0] s2_addr;
  logic [NB-1:0] s2_mask;
  logic [DW-1:0] rd_word;
  logic [DW-1:0] dout_d;
  logic          drv_d;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    always_ff @(posedge clk) begin
      if (cke && (s2_op == OP_WR) && s2_mask[b])
        lane_mem[s2_addr] <= wdata[8*b +: 8];
    end
    assign rd_word[8*b +: 8] = lane_mem[s2_addr];
  end

  always_comb begin
    drv_d  = (s2_op == OP_RD);
    dout_d = (s2_op == OP_RD) ? rd_word : dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_NONE;
      s1_addr <= '0;
      s1_mask <= '0;
      s2_op   <= OP_NONE;
      s2_addr <= '0;
      s2_mask <= '0;
      drv_q   <= 1'b0;
      dout_q  <= '0;
    end else if (cke) begin
      s1_op   <= op_in;
      s1_addr <= addr_in;
      s1_mask <= mask_in;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
      drv_q   <= drv_d;
      dout_q  <= dout_d;
    end
  end
endmodule

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cken_n,
  input  logic                 cs_n,
  input  logic                 cs,
  input  logic                 adv,
  input  logic                 we_n,
  input  logic [BYTES-1:0]     bw_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 oe_n,
  input  logic                 sleep,
  input  logic [8*BYTES-1:0]   wdata,
  output logic [8*BYTES-1:0]   rdata,
  output logic                 dq_oe
);
  logic [1:0]        rs_q;
  logic              rst_s_n;
  logic              cke;
  op_e               cmd_op;
  logic [ADDR_W-1:0] eff_addr;
  logic [BYTES-1:0]  cmd_mask;
  logic              upd;
  bkind_e            bkind_d;
  bkind_e            bkind_q;
  logic [ADDR_W-3:0] base_hi_q;
  logic [1:0]        cnt_q;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [BYTES-1:0]  s1_mask;
  op_e               s2_op;
  logic              drv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];
  assign cke     = !cken_n;

  pbs_cmd_decode #(.AW(ADDR_W), .NB(BYTES)) dec_i (
    .sleep(sleep), .cs_n(cs_n), .cs(cs), .adv(adv), .we_n(we_n),
    .bw_n(bw_n), .addr(addr), .bkind_q(bkind_q), .base_hi_q(base_hi_q),
    .cnt_q(cnt_q), .op(cmd_op), .eff_addr(eff_addr), .mask(cmd_mask),
    .upd(upd), .bkind_d(bkind_d)
  );

  pbs_burst_addr #(.AW(ADDR_W)) bctr_i (
    .clk(clk), .rst_n(rst_s_n), .cke(cke), .upd(upd), .eff_addr(eff_addr),
    .bkind_d(bkind_d), .bkind_q(bkind_q), .base_hi_q(base_hi_q), .cnt_q(cnt_q)
  );

  pbs_data_pipe #(.AW(ADDR_W), .NB(BYTES)) pipe_i (
    .clk(clk), .rst_n(rst_s_n), .cke(cke), .op_in(cmd_op),
    .addr_in(eff_addr), .mask_in(cmd_mask), .wdata(wdata),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_mask(s1_mask), .s2_op(s2_op),
    .drv_q(drv_q), .dout_q(rdata)
  );

  assign dq_oe = drv_q && !oe_n && !sleep;
endmodule

// File: rtl/pbsram_ctrl_chk.sv
module pbsram_ctrl_chk
  import pbs_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_s_n,
  input logic          cken_n,
  input logic          sleep,
  input logic          adv,
  input logic [NB-1:0] bw_n,
  input op_e           cmd_op,
  input bkind_e        bkind_q,
  input logic [AW-3:0] base_hi_q,
  input logic [1:0]    cnt_q,
  input op_e           s1_op,
  input logic [AW-1:0] s1_addr,
  input logic [NB-1:0] s1_mask,
  input op_e           s2_op,
  input logic          drv_q,
  input logic [8*NB-1:0] rdata
);
  p_rd_drives_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cken_n && s2_op == OP_RD) |=> drv_q);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cken_n && !sleep && adv && bkind_q != BK_IDLE) |=>
      (s1_addr[1:0] == 2'($past(cnt_q) + 2'd1)) && (s1_addr[AW-1:2] == $past(base_hi_q)));

  p_abort_mask_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cken_n && cmd_op == OP_WR && (&bw_n)) |=> (s1_op == OP_WR) && (s1_mask == '0));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    cken_n |=> $stable(drv_q) && $stable(rdata) && $stable(s1_op) && $stable(cnt_q));

  p_write_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cken_n && s2_op == OP_WR) |=> !drv_q);

  p_sleep_deselect_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!cken_n && sleep) |=> (s1_op == OP_NONE) && (bkind_q == BK_IDLE));
endmodule

bind pbsram_ctrl pbsram_ctrl_chk #(.AW(ADDR_W), .NB(BYTES)) chk_i (
  .clk(clk), .rst_s_n(rst_s_n), .cken_n(cken_n), .sleep(sleep), .adv(adv),
  .bw_n(bw_n), .cmd_op(cmd_op), .bkind_q(bkind_q), .base_hi_q(base_hi_q),
  .cnt_q(cnt_q), .s1_op(s1_op), .s1_addr(s1_addr), .s1_mask(s1_mask),
  .s2_op(s2_op), .drv_q(drv_q), .rdata(rdata)
);

// File: tb/pbsram_ctrl_tb_top.sv
module pbsram_ctrl_tb_top;
  localparam int AW    = 6;
  localparam int NB    = 2;
  localparam int DW    = 8 * NB;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cken_n, cs_n, cs, adv, we_n, oe_n, sleep;
  logic [NB-1:0] bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          dq_oe;

  int vectors = 0;
  int fails   = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pbsram_ctrl #(.ADDR_W(AW), .BYTES(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .cs_n(cs_n), .cs(cs),
    .adv(adv), .we_n(we_n), .bw_n(bw_n), .addr(addr), .oe_n(oe_n),
    .sleep(sleep), .wdata(wdata), .rdata(rdata), .dq_oe(dq_oe)
  );

  // Behavioural reference: queue of pending operations (0 none, 1 read, 2 write)
  logic [DW-1:0] mm [DEPTH];
  int            q_op[$];
  int            q_a[$];
  int            q_m[$];
  int            kind, base, cnt, m_op, m_a, m_m;
  logic          exp_drv;
  logic [DW-1:0] exp_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_op = '{0, 0}; q_a = '{0, 0}; q_m = '{0, 0};
      kind = 0; base = 0; cnt = 0; exp_drv = 1'b0; exp_data = '0;
    end else if (!cken_n) begin
      m_op = q_op.pop_front(); m_a = q_a.pop_front(); m_m = q_m.pop_front();
      exp_drv = (m_op == 1);
      if (m_op == 1) exp_data = mm[m_a];
      if (m_op == 2)
        for (int b = 0; b < NB; b++)
          if (m_m[b]) mm[m_a][8*b +: 8] = wdata[8*b +: 8];
      if (sleep) begin
        kind = 0; q_op.push_back(0); q_a.push_back(0); q_m.push_back(0);
      end else if (!adv) begin
        if (!cs_n && cs) begin
          base = int'(addr); cnt = base % 4;
          kind = we_n ? 1 : 2;
          q_op.push_back(kind); q_a.push_back(base);
          q_m.push_back(we_n ? 0 : int'(~bw_n));
        end else begin
          kind = 0; q_op.push_back(0); q_a.push_back(0); q_m.push_back(0);
        end
      end else if (kind == 0) begin
        q_op.push_back(0); q_a.push_back(0); q_m.push_back(0);
      end else begin
        cnt = (cnt + 1) % 4;
        q_op.push_back(kind); q_a.push_back((base & ~3) | cnt);
        q_m.push_back(kind == 2 ? int'(~bw_n) : 0);
      end
    end
  end

  task automatic compare();
    logic eo;
    eo = exp_drv && !oe_n && !sleep;
    vectors++;
    if (dq_oe !== eo) begin
      fails++;
      $display("FAIL %s: dq_oe actual %b expected %b", cur_req, dq_oe, eo);
    end else if (eo && rdata !== exp_data) begin
      fails++;
      $display("FAIL %s: rdata actual %h expected %h", cur_req, rdata, exp_data);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    wdata = DW'($urandom);
  endtask

  task automatic idle_in();
    cken_n = 1'b0; cs_n = 1'b1; cs = 1'b1; adv = 1'b0; we_n = 1'b1;
    bw_n = '1; addr = '0; oe_n = 1'b0; sleep = 1'b0;
  endtask

  task automatic ld_rd(input int a);
    cken_n = 1'b0; cs_n = 1'b0; cs = 1'b1; adv = 1'b0; we_n = 1'b1;
    addr = AW'(a); tick();
  endtask

  task automatic ld_wr(input int a, input logic [NB-1:0] bwn);
    cken_n = 1'b0; cs_n = 1'b0; cs = 1'b1; adv = 1'b0; we_n = 1'b0;
    bw_n = bwn; addr = AW'(a); tick();
  endtask

  task automatic cont(input logic [NB-1:0] bwn);
    cken_n = 1'b0; adv = 1'b1; bw_n = bwn; addr = AW'($urandom); tick();
  endtask

  task automatic desel();
    cken_n = 1'b0; cs_n = 1'b1; adv = 1'b0; tick();
  endtask

  task automatic stall();
    cken_n = 1'b1; adv = 1'($urandom); cs_n = 1'($urandom); we_n = 1'($urandom);
    tick();
    we_n = 1'b1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    idle_in();
    wdata = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    // R1: reset state
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    cur_req = "R7";
    cont('1); cont('1);   // R7: continue after reset is a no-op
    // R3 fill every word with full-width writes in bursts
    cur_req = "R3";
    for (int w = 0; w < DEPTH; w += 4) begin
      ld_wr(w, '0); cont('0); cont('0); cont('0);
    end
    desel(); desel();
    // R2 R4 R5: read bursts with unaligned start, wrapping
    cur_req = "R4";
    ld_rd(6); cont('1); cont('1); cont('1);
    ld_rd(13); cont('1); cont('1); cont('1);
    cur_req = "R2";
    desel(); desel(); desel();
    // R3 R5: alternating write and read bursts, partial byte masks
    cur_req = "R3";
    ld_wr(21, 2'b10); ld_rd(21); ld_wr(22, 2'b01); ld_rd(22);
    ld_wr(30, 2'b00); cont(2'b01); cont(2'b10); cont(2'b00);
    cur_req = "R5";
    ld_rd(30); cont('1); cont('1); cont('1);
    // R6: write abort then read back
    cur_req = "R6";
    ld_wr(40, '1); cont('1); cont('1); ld_rd(40); cont('1); cont('1); cont('1);
    desel(); desel();
    // R7: deselect then deselect-continue
    cur_req = "R7";
    desel(); cont('0); cont('0); cont('0); ld_rd(41); desel(); cont('1); cont('1);
    desel();
    // R8: stalls inside read and write bursts
    cur_req = "R8";
    ld_rd(8); cont('1); stall(); stall(); cont('1); stall(); cont('1);
    ld_wr(9, 2'b00); stall(); cont(2'b00); stall(); stall(); ld_rd(9); stall();
    cont('1); stall(); desel(); desel(); stall();
    // R9: dummy read with output enable high, and write cycles
    cur_req = "R9";
    oe_n = 1'b1; ld_rd(3); cont('1); cont('1); oe_n = 1'b0; cont('1);
    ld_wr(3, 2'b00); cont(2'b00); desel(); desel();
    // R10: sleep during a read burst, async drive removal
    cur_req = "R10";
    ld_rd(16); cont('1); cont('1);
    sleep = 1'b1;
    #2;
    vectors++;
    if (dq_oe !== 1'b0) begin
      fails++;
      $display("FAIL R10: async dq_oe actual %b expected 0", dq_oe);
    end
    tick(); cont('1); tick();
    sleep = 1'b0;
    cont('1); ld_rd(16); cont('1); cont('1); cont('1); desel();
    // Random mix across all requirements
    cur_req = "R5";
    for (int i = 0; i < 3000; i++) begin
      cken_n = ($urandom % 6) == 0;
      cs_n   = ($urandom % 5) == 0;
      cs     = ($urandom % 7) != 0;
      adv    = ($urandom % 2) == 0;
      we_n   = 1'($urandom);
      bw_n   = NB'($urandom);
      addr   = AW'($urandom);
      oe_n   = ($urandom % 8) == 0;
      sleep  = ($urandom % 25) == 0;
      tick();
    end
    summary();
    $finish;
  end
endmodule